// File: doc/BRIEF.md
# Passcode-Guarded Interrupt Register Front-End

This block is the register face of a peripheral whose configuration must not be changed by accident. It answers 32-bit word accesses on a simple strobe bus. One lock register guards every other register. While the lock holds, writes anywhere except the lock register are dropped. Software lifts the lock by writing one specific 16-bit key as the full word. Any other value written to the lock register closes it again.

Behind the lock sits an interrupt register set with 16 sources: bits 14:0 and bit 31. The set has four registers:
- A status register whose bits hardware events set and software clears by writing 1.
- A mask register that can only be read.
- A write-only enable register that clears mask bits.
- A write-only disable register that sets mask bits.

A single level interrupt is high while any status bit is set and its mask bit is clear. Register offsets: lock 0x00, status 0x30, mask 0x34, enable 0x38, disable 0x3C.

Top module: `lockreg_irq`

## Requirements
- R1: After reset the lock register reads 1, status reads 0x00000000, mask reads 0x80007FFF and `irq_o` is low.
- R2: A write to offset 0x00 is always accepted. It stores 0 only when the whole 32-bit write word equals 0x0000DF0D, and stores 1 for any other value, including 0x0001DF0D. Offset 0x00 reads back the stored bit in bit 0.
- R3: While the lock register holds 1, writes to every offset other than 0x00 have no effect on any register.
- R4: Status (0x30) is write-1-to-clear on bits 31 and 14:0. Bits 30:15 of status and mask always read 0, and writing 1 to them changes nothing.
- R5: Mask (0x34) cannot be written directly. A write to 0x34 leaves it unchanged.
- R6: Writing 1 to a bit of the enable register (0x38) clears that mask bit, and writing 0 leaves it unchanged. Offset 0x38 reads 0.
- R7: Writing 1 to a bit of the disable register (0x3C) sets that mask bit, and writing 0 leaves it unchanged. Offset 0x3C reads 0.
- R8: `irq_o` is high exactly when some status bit is 1 and the same mask bit is 0. It follows a status, enable, disable or event change in the cycle after the clock edge that registers it.
- R9: Event input bit i (for i = 0..14) sets status bit i, and event bit 15 sets status bit 31. Only a software clear or reset clears a status bit. When an event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R10: Offsets not listed above, and any offset with address bits 1:0 not zero, read 0 and ignore writes. `rd_data_o` is 0 whenever `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the access |
| wr_data_i | input | 32 | Write word |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe; read data is valid in the same cycle |
| ev_i | input | N_LOW+1 | Hardware event pulses |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt |

## Verification
The bound checker checks the following on every clock:
- that a lock write stores exactly the key comparison;
- that a locked write to any other offset leaves status and mask unchanged;
- that the reserved bits stay zero;
- that a direct mask write does nothing;
- that any event bit is set in status one cycle later, which also covers the case where a clear lands in the same cycle;
- that the interrupt only rises after an event or a write.

The bench's behavioural model compares read data and the interrupt level every cycle. Several properties can only be seen through its scenarios:
- the near-miss keys;
- the read-as-zero of the enable and disable registers;
- the exact level of `irq_o` under mixed enable and disable sequences;
- misaligned and unmapped accesses;
- relocking.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;

    // Slot indices of the decoded register map
    localparam int SL_LOCK = 0;
    localparam int SL_STAT = 1;
    localparam int SL_MASK = 2;
    localparam int SL_EN   = 3;
    localparam int SL_DIS  = 4;
    localparam int N_SLOT  = 5;

    // Byte offsets, 12 bits wide; the address is zero-extended before compare
    localparam logic [11:0] SLOT_OFS [N_SLOT] = '{
        12'h000, 12'h030, 12'h034, 12'h038, 12'h03C
    };

    localparam logic [31:0] UNLOCK_KEY = 32'h0000_DF0D;

    // Source-bit map: low field of n bits plus the top bit
    function automatic logic [31:0] src_bits(input int n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        m[31] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic [31:0] status;
        logic [31:0] mask;
    } irq_state_t;

    typedef struct packed {
        logic locked;
    } lock_state_t;

endpackage

// File: rtl/lockreg_decode.sv
module lockreg_decode
    import lockreg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [N_SLOT-1:0] sel_o
);
    logic [11:0] addr_x;
    logic        aligned;

    assign addr_x  = 12'(addr_i);
    assign aligned = (addr_i[1:0] == 2'b00);

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        assign sel_o[g] = aligned && (addr_x == SLOT_OFS[g]);
    end
endmodule

// File: rtl/lockreg_lock.sv
module lockreg_lock
    import lockreg_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_i,
    input  logic [31:0] wr_data_i,
    output logic        locked_o
);
    lock_state_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (wr_i) lk_d.locked = (wr_data_i != UNLOCK_KEY);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lk_q <= '{locked: 1'b1};
        else         lk_q <= lk_d;
    end

    assign locked_o = lk_q.locked;
endmodule

// File: rtl/lockreg_irqset.sv
module lockreg_irqset
    import lockreg_pkg::*;
#(
    parameter int N_LOW = 15
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           stat_wr_i,
    input  logic           en_wr_i,
    input  logic           dis_wr_i,
    input  logic [31:0]    wr_data_i,
    input  logic [N_LOW:0] ev_i,
    output logic [31:0]    status_o,
    output logic [31:0]    mask_o,
    output logic           irq_o
);
    localparam logic [31:0] SRC = src_bits(N_LOW);

    irq_state_t st_d, st_q;
    logic [31:0] ev_x;
    logic [31:0] wbits;

    always_comb begin
        ev_x = '0;
        for (int i = 0; i < N_LOW; i++) ev_x[i] = ev_i[i];
        ev_x[31] = ev_i[N_LOW];
    end

    assign wbits = wr_data_i & SRC;

    always_comb begin
        st_d = st_q;
        if (stat_wr_i) st_d.status = st_q.status & ~wbits;
        if (en_wr_i)   st_d.mask   = st_q.mask & ~wbits;
        if (dis_wr_i)  st_d.mask   = st_q.mask | wbits;
        // events applied last: a set wins over a same-cycle clear
        st_d.status = st_d.status | ev_x;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{status: 32'h0, mask: SRC};
        else         st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = |(st_q.status & ~st_q.mask);
endmodule

// File: rtl/lockreg_irq.sv
module lockreg_irq
    import lockreg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_LOW  = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [N_LOW:0]    ev_i,
    output logic [31:0]       rd_data_o,
    output logic              irq_o
);
    logic [N_SLOT-1:0] sel;
    logic              locked;
    logic              wr_ok;
    logic [31:0]       status;
    logic [31:0]       mask;

    lockreg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    lockreg_lock u_lock (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_en_i && sel[SL_LOCK]),
        .wr_data_i (wr_data_i),
        .locked_o  (locked)
    );

    assign wr_ok = wr_en_i && !locked;

    lockreg_irqset #(.N_LOW(N_LOW)) u_irq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .stat_wr_i (wr_ok && sel[SL_STAT]),
        .en_wr_i   (wr_ok && sel[SL_EN]),
        .dis_wr_i  (wr_ok && sel[SL_DIS]),
        .wr_data_i (wr_data_i),
        .ev_i      (ev_i),
        .status_o  (status),
        .mask_o    (mask),
        .irq_o     (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i) begin
            if (sel[SL_LOCK])      rd_data_o = {31'b0, locked};
            else if (sel[SL_STAT]) rd_data_o = status;
            else if (sel[SL_MASK]) rd_data_o = mask;
        end
    end
endmodule

// File: rtl/lockreg_irq_chk.sv
module lockreg_irq_chk
    import lockreg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_LOW  = 15
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic [31:0]       wr_data_i,
    input logic              wr_en_i,
    input logic [N_LOW:0]    ev_i,
    input logic              irq_o,
    input logic              locked,
    input logic [31:0]       status,
    input logic [31:0]       mask
);
    localparam logic [31:0] SRC = src_bits(N_LOW);

    logic [11:0] a_x;
    logic [31:0] ev_x;

    assign a_x = 12'(addr_i);

    always_comb begin
        ev_x = '0;
        for (int i = 0; i < N_LOW; i++) ev_x[i] = ev_i[i];
        ev_x[31] = ev_i[N_LOW];
    end

    p_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && a_x == 12'h000) |=> (locked == ($past(wr_data_i) != UNLOCK_KEY)));

    p_guard_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked && wr_en_i && a_x != 12'h000 && ev_i == '0) |=> ($stable(status) && $stable(mask)));

    p_rsvd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status & ~SRC) == 32'h0) && ((mask & ~SRC) == 32'h0));

    p_mask_ro_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && a_x == 12'h034) |=> $stable(mask));

    p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> ($past(ev_i) != '0 || $past(wr_en_i)));

    p_evt_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_x != 32'h0) |=> ((status & $past(ev_x)) == $past(ev_x)));
endmodule

bind lockreg_irq lockreg_irq_chk #(.ADDR_W(ADDR_W), .N_LOW(N_LOW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .wr_en_i   (wr_en_i),
    .ev_i      (ev_i),
    .irq_o     (irq_o),
    .locked    (locked),
    .status    (status),
    .mask      (mask)
);

// File: tb/lockreg_irq_test.sv
`timescale 1ns/1ps
module lockreg_irq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] ev = '0;
    logic [31:0] rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // behavioural reference state
    int unsigned m_lock, m_stat, m_mask;
    localparam int unsigned SRCM = 32'h8000_7FFF;

    always #2.5 clk = ~clk;

    lockreg_irq uut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_data_i(wdata),
        .wr_en_i(wr), .rd_en_i(rd), .ev_i(ev), .rd_data_o(rdata), .irq_o(irq)
    );

    function automatic int unsigned m_read(input logic [7:0] a);
        if (a[1:0] != 2'b00) return 0;
        case (a)
            8'h00: return m_lock;
            8'h30: return m_stat;
            8'h34: return m_mask;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive, compare against model, advance model, clock
    task automatic cyc(input bit w, input bit r, input logic [7:0] a,
                       input logic [31:0] d, input logic [15:0] e, input string tag);
        int unsigned wb;
        @(negedge clk);
        wr = w; rd = r; addr = a; wdata = d; ev = e;
        #1;
        check({tag, " rd_data"}, rdata, r ? m_read(a) : 0);
        check({tag, " R8 irq"}, {31'b0, irq}, ((m_stat & ~m_mask) != 0) ? 1 : 0);
        wb = d & SRCM;
        if (w) begin
            if (a == 8'h00) m_lock = (d != 32'h0000DF0D) ? 1 : 0;
            else if (m_lock == 0) begin
                case (a)
                    8'h30: m_stat = m_stat & ~wb;
                    8'h38: m_mask = m_mask & ~wb;
                    8'h3C: m_mask = m_mask | wb;
                    default: ;
                endcase
            end
        end
        m_stat = m_stat | {e[15], 16'b0, e[14:0]};
    endtask

    task automatic rdc(input logic [7:0] a, input string tag);
        cyc(1'b0, 1'b1, a, 32'h0, 16'h0, tag);
    endtask

    task automatic wrc(input logic [7:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, 1'b0, a, d, 16'h0, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_lock = 1; m_stat = 0; m_mask = SRCM;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdc(8'h00, "R1 lock");
        rdc(8'h30, "R1 status");
        rdc(8'h34, "R1 mask");

        // R3 locked writes dropped
        wrc(8'h38, 32'hFFFF_FFFF, "R3 enable locked");
        rdc(8'h34, "R3 mask after locked enable");
        cyc(1'b0, 1'b0, 8'h00, 32'h0, 16'h0001, "R9 event bit0");
        wrc(8'h30, 32'hFFFF_FFFF, "R3 clear locked");
        rdc(8'h30, "R3 status kept");

        // R2 key handling
        wrc(8'h00, 32'h0001_DF0D, "R2 near key high");
        rdc(8'h00, "R2 still locked");
        wrc(8'h00, 32'h0000_DF0C, "R2 near key low");
        rdc(8'h00, "R2 still locked 2");
        wrc(8'h00, 32'h0000_DF0D, "R2 key");
        rdc(8'h00, "R2 unlocked");

        // R6 enable and R8 irq
        wrc(8'h38, 32'h0000_0001, "R6 enable bit0");
        rdc(8'h34, "R6 mask");
        rdc(8'h38, "R6 enable reads zero");

        // R5 mask read-only
        wrc(8'h34, 32'h0000_0000, "R5 mask write");
        rdc(8'h34, "R5 mask kept");

        // R4 W1C and reserved bits
        wrc(8'h30, 32'h7FFF_8000, "R4 reserved clear");
        rdc(8'h30, "R4 status kept");
        wrc(8'h38, 32'h7FFF_8000, "R4 reserved enable");
        rdc(8'h34, "R4 mask reserved");
        wrc(8'h30, 32'hFFFF_FFFF, "R4 clear all");
        rdc(8'h30, "R4 status zero");

        // R9 bit 15 maps to status 31, then mixed pattern
        cyc(1'b0, 1'b0, 8'h00, 32'h0, 16'h8000, "R9 event top");
        rdc(8'h30, "R9 status top");
        wrc(8'h38, 32'h8000_0000, "R6 enable top");
        rdc(8'h30, "R8 irq top");
        cyc(1'b0, 1'b0, 8'h00, 32'h0, 16'h5A5A, "R9 pattern");
        rdc(8'h30, "R9 pattern status");

        // R9 set wins over same-cycle clear
        cyc(1'b1, 1'b0, 8'h30, 32'h0000_0006, 16'h0004, "R9 set vs clear");
        rdc(8'h30, "R9 bit2 kept bit1 cleared");

        // R7 disable
        wrc(8'h3C, 32'h8000_0000, "R7 disable top");
        rdc(8'h34, "R7 mask");
        rdc(8'h3C, "R7 disable reads zero");
        wrc(8'h3C, 32'h0000_0000, "R7 disable zero");
        rdc(8'h34, "R7 mask unchanged");
        wrc(8'h38, 32'h0000_0400, "R6 enable bit10");
        wrc(8'h30, 32'h0000_0400, "R8 clear bit10");
        rdc(8'h30, "R8 after clear");

        // R10 unmapped and misaligned
        wrc(8'h31, 32'hFFFF_FFFF, "R10 misaligned write");
        rdc(8'h30, "R10 status kept");
        rdc(8'h31, "R10 misaligned read");
        wrc(8'h44, 32'hFFFF_FFFF, "R10 unmapped write");
        rdc(8'h44, "R10 unmapped read");
        cyc(1'b0, 1'b0, 8'h30, 32'h0, 16'h0, "R10 no read strobe");

        // relock
        wrc(8'h00, 32'h0000_1234, "R2 relock");
        rdc(8'h00, "R2 relocked");
        wrc(8'h3C, 32'hFFFF_FFFF, "R3 disable locked");
        rdc(8'h34, "R3 mask kept");
        cyc(1'b0, 1'b0, 8'h00, 32'h0, 16'h0, "R8 idle");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule